// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns four external interrupt pins into four qualified request lines for a downstream priority resolver. Pin 0 feeds the critical group and pins 1 to 3 feed the main group; the resolver itself sits outside. One packed 32-bit control word holds everything software sets: a 2-bit sense mode per pin, a per-pin enable, a global external enable and a critical-routing select. Write-1-to-clear acknowledge bits in the same word drop latched edge requests.

Every pin goes through a two-flop synchronizer. In a level mode a request follows the synchronized pin while that pin is at its active level. In an edge mode the chosen edge sets a sticky pending latch, and the latch holds until software acknowledges it. The control word is written through a plain write strobe and read back at any time. There is no streamed data path, so no valid/ready handshake is used and nothing applies back-pressure. Software re-initialises the block by writing the word back with bits 23:16 unchanged, which keeps the sense setup of every pin.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control word reads 0x00000000, every request output is 0 and the routing output is 0.
- R2: Field layout. The sense mode of pin n is stored at bits (23-2n):(22-2n). The enable of pin n is at bit (11-n), with 1 meaning enabled. The global enable is at bit 12 and the routing select at bit 0. Every other bit, including the acknowledge bits 27:24, reads back as 0. So writing 0xFFFFFFFF reads back as 0x00FF1F01.
- R3: Sense code 0 (level high). The request follows the pin being 1. A pin change shows at the request after exactly two rising clock edges, and not after one.
- R4: Sense code 3 (level low). The request is active while the synchronized pin is 0.
- R5: Sense code 1 (rising edge). A 0-to-1 transition on the synchronized pin sets a pending latch. The request stays 1 after the pin returns low, until that pin is acknowledged.
- R6: Sense code 2 (falling edge). A 1-to-0 transition sets the pending latch. A rising transition does not set it.
- R7: A write with bit (27-n) set clears pin n's pending latch on that write's clock edge. Acknowledge bits at 0 and acknowledges to other pins leave that pin's latch unchanged. If an edge is detected in the same cycle as the acknowledge, the edge wins.
- R8: A request output is 1 only when both the pin's enable and the global enable are 1. An edge seen while the pin is disabled stays latched and appears as soon as the pin is enabled.
- R9: The routing output equals the stored bit 0 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word value to write, including acknowledge bits |
| rd_data | output | 32 | Current control word read-back |
| pin_i | input | 4 | Asynchronous external interrupt pins, index = pin number |
| req_o | output | 4 | Qualified request per pin (0 critical, 1..3 main) |
| crit_route_o | output | 1 | Critical-request routing select (bit 0) |

## Verification
The bench probes the bit positions by writing all ones and comparing the read-back. A design that stored the acknowledge bits, or that left the fields unmirrored, would return a different word. It also checks the request one edge after a pin change to catch a synchronizer that is one flop short.

For the edge modes, it acknowledges the wrong pin before the right one, so a clear that hits every pin or ignores the index shows up as a lost request. It also sends a rising pulse into a falling-edge pin to catch a swapped encoding.

Finally, it latches an edge while the pin is disabled and then enables the pin. A design that gated the latch instead of the output would lose that event, and a design that ignored the global enable would raise a request with that enable off.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
  localparam int NPINS      = 4;
  localparam int WORD_W     = 32;
  localparam int SENSE_TOP  = 23;
  localparam int EN_TOP     = 11;
  localparam int ACK_TOP    = 27;
  localparam int GLOBAL_BIT = 12;
  localparam int ROUTE_BIT  = 0;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SNS_LVL_HI = 2'd0,
    SNS_RISE   = 2'd1,
    SNS_FALL   = 2'd2,
    SNS_LVL_LO = 2'd3
  } sense_e;
endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/eisc_chan.sv
module eisc_chan
  import eisc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_e mode,
  input  logic   ack,
  output logic   active_o
);
  logic prev_q;
  logic pend_q;
  logic edge_mode;
  logic hit;

  assign edge_mode = (mode == SNS_RISE) || (mode == SNS_FALL);
  assign hit = ((mode == SNS_RISE) &&  pin_s && !prev_q) ||
               ((mode == SNS_FALL) && !pin_s &&  prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (!edge_mode)  pend_q <= 1'b0;
      else if (hit)    pend_q <= 1'b1;
      else if (ack)    pend_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode)
      SNS_LVL_HI: active_o = pin_s;
      SNS_LVL_LO: active_o = !pin_s;
      default:    active_o = pend_q;
    endcase
  end

  // R5/R7: a detected edge always lands in the latch, even beside an ack
  a_r5_edge_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && hit) |=> pend_q);
  // R7: an ack with no competing edge empties the latch
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !hit) |=> !pend_q);
  // R5: without ack the latch is sticky while the mode stays an edge mode
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend_q && !ack && $stable(mode)) |=> pend_q);
endmodule

// File: rtl/eisc_regs.sv
module eisc_regs
  import eisc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output sense_e            mode_o [NPINS],
  output logic [NPINS-1:0]  pin_en_o,
  output logic              global_en_o,
  output logic              route_o,
  output logic [NPINS-1:0]  ack_o
);
  sense_e           mode_q [NPINS];
  logic [NPINS-1:0] en_q;
  logic             glob_q;
  logic             route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NPINS; n++) mode_q[n] <= SNS_LVL_HI;
      en_q    <= '0;
      glob_q  <= 1'b0;
      route_q <= 1'b0;
    end else if (wr_en) begin
      for (int n = 0; n < NPINS; n++) begin
        mode_q[n] <= sense_e'(wr_data[SENSE_TOP-2*n -: 2]);
        en_q[n]   <= wr_data[EN_TOP-n];
      end
      glob_q  <= wr_data[GLOBAL_BIT];
      route_q <= wr_data[ROUTE_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int n = 0; n < NPINS; n++) begin
      rd_data[SENSE_TOP-2*n -: 2] = mode_q[n];
      rd_data[EN_TOP-n]           = en_q[n];
    end
    rd_data[GLOBAL_BIT] = glob_q;
    rd_data[ROUTE_BIT]  = route_q;
  end

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_ack
      assign ack_o[g] = wr_en && wr_data[ACK_TOP-g];
    end
  endgenerate

  assign mode_o      = mode_q;
  assign pin_en_o    = en_q;
  assign global_en_o = glob_q;
  assign route_o     = route_q;

  // R2: acknowledge bits are never held in the read-back word
  a_r2_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[ACK_TOP -: NPINS] == '0));
  // R9: the routing bit tracks the last written value
  a_r9_route_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (route_o == $past(wr_data[ROUTE_BIT])));
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eisc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [3:0]  pin_i,
  output logic [3:0]  req_o,
  output logic        crit_route_o
);
  logic [NPINS-1:0] pin_s;
  sense_e           mode [NPINS];
  logic [NPINS-1:0] pin_en;
  logic             glob_en;
  logic [NPINS-1:0] ack;
  logic [NPINS-1:0] active;

  eisc_sync #(.WIDTH(NPINS), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_s)
  );

  eisc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mode_o(mode), .pin_en_o(pin_en),
    .global_en_o(glob_en), .route_o(crit_route_o), .ack_o(ack)
  );

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_chan
      eisc_chan u_chan (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s[g]), .mode(mode[g]),
        .ack(ack[g]), .active_o(active[g])
      );
      assign req_o[g] = active[g] && pin_en[g] && glob_en;

      // R8: no request leaves a disabled pin
      a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
        req_o[g] |-> (rd_data[EN_TOP-g] && rd_data[GLOBAL_BIT]));
    end
  endgenerate
endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pin_i = '0;
  logic [3:0]  req_o;
  logic        crit_route_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_i(pin_i), .req_o(req_o), .crit_route_o(crit_route_o)
  );

  function automatic logic [31:0] cfg(input logic [1:0] s0, s1, s2, s3,
                                      input logic [3:0] en, input logic glob,
                                      input logic route, input logic [3:0] ack);
    logic [31:0] w = '0;
    w[23:22] = s0; w[21:20] = s1; w[19:18] = s2; w[17:16] = s3;
    for (int n = 0; n < 4; n++) begin
      w[11-n] = en[n];
      w[27-n] = ack[n];
    end
    w[12] = glob; w[0] = route;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 rd", rd_data, 32'h0);
    check("R1 req", {28'h0, req_o}, 32'h0);
    check("R1 route", {31'h0, crit_route_o}, 32'h0);
  endtask

  task automatic t_layout;
    wr(32'hFFFF_FFFF);
    check("R2 readback", rd_data, 32'h00FF_1F01);
    check("R4 level low idle pins", {28'h0, req_o}, 32'hF);
    wr(32'h0);
    check("R2 cleared", rd_data, 32'h0);
  endtask

  task automatic t_level_high;
    wr(cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'hF, 1'b1, 1'b0, 4'h0));
    @(negedge clk); pin_i[1] = 1'b1;
    cyc(1);
    check("R3 one edge latency", {28'h0, req_o}, 32'h0);
    cyc(1);
    check("R3 two edge latency", {28'h0, req_o}, 32'h2);
    pin_i[1] = 1'b0;
    cyc(2);
    check("R3 follows low", {28'h0, req_o}, 32'h0);
  endtask

  task automatic t_level_low;
    wr(cfg(2'd0, 2'd0, 2'd0, 2'd3, 4'hF, 1'b1, 1'b0, 4'h0));
    check("R4 low active", {28'h0, req_o}, 32'h8);
    @(negedge clk); pin_i[3] = 1'b1;
    cyc(3);
    check("R4 high inactive", {28'h0, req_o}, 32'h0);
    pin_i[3] = 1'b0;
    cyc(3);
  endtask

  task automatic t_rising;
    logic [31:0] c;
    c = cfg(2'd0, 2'd0, 2'd1, 2'd0, 4'hF, 1'b1, 1'b0, 4'h0);
    wr(c);
    @(negedge clk); pin_i[2] = 1'b1;
    cyc(3); pin_i[2] = 1'b0;
    cyc(4);
    check("R5 sticky after pulse", {28'h0, req_o}, 32'h4);
    wr(c | cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h1));
    check("R7 other pin ack", {28'h0, req_o}, 32'h4);
    wr(c);
    check("R7 zero ack bits", {28'h0, req_o}, 32'h4);
    wr(c | cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h4));
    check("R7 own ack", {28'h0, req_o}, 32'h0);
  endtask

  task automatic t_falling;
    logic [31:0] c;
    c = cfg(2'd0, 2'd0, 2'd0, 2'd2, 4'hF, 1'b1, 1'b0, 4'h0);
    wr(c);
    @(negedge clk); pin_i[3] = 1'b1;
    cyc(4);
    check("R6 rising ignored", {28'h0, req_o}, 32'h0);
    pin_i[3] = 1'b0;
    cyc(4);
    check("R6 falling latched", {28'h0, req_o}, 32'h8);
    wr(c | cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'h0, 1'b0, 1'b0, 4'h8));
    check("R6 ack", {28'h0, req_o}, 32'h0);
  endtask

  task automatic t_gating;
    wr(cfg(2'd0, 2'd0, 2'd1, 2'd0, 4'hB, 1'b1, 1'b0, 4'h0));
    @(negedge clk); pin_i[2] = 1'b1;
    cyc(3); pin_i[2] = 1'b0;
    cyc(4);
    check("R8 disabled pin", {28'h0, req_o}, 32'h0);
    wr(cfg(2'd0, 2'd0, 2'd1, 2'd0, 4'hF, 1'b1, 1'b0, 4'h0));
    check("R8 latched while disabled", {28'h0, req_o}, 32'h4);
    wr(cfg(2'd0, 2'd0, 2'd1, 2'd0, 4'hF, 1'b0, 1'b0, 4'h0));
    check("R8 global off", {28'h0, req_o}, 32'h0);
    wr(cfg(2'd0, 2'd0, 2'd1, 2'd0, 4'hF, 1'b1, 1'b0, 4'h4));
    check("R8 acked", {28'h0, req_o}, 32'h0);
  endtask

  task automatic t_route;
    wr(cfg(2'd0, 2'd0, 2'd0, 2'd0, 4'h0, 1'b0, 1'b1, 4'h0));
    check("R9 route set", {31'h0, crit_route_o}, 32'h1);
    wr(32'h0);
    check("R9 route clear", {31'h0, crit_route_o}, 32'h0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_layout();
    t_level_high();
    t_level_low();
    t_rising();
    t_falling();
    t_gating();
    t_route();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        cyc(20000);
        vectors++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule